// File: doc/BRIEF.md
# USB Dual-Role Core Interrupt Controller

This block keeps the interrupt status word and the interrupt enable word of a dual-role USB controller core, and drives one level-sensitive interrupt line to the host processor. The protocol logic sends it one-cycle event pulses for frame start, resume/wakeup, session request and disconnect. It also sends a level that summarises the OTG sub-event register. A separate decoded access stream tells the block when software touches a register region that belongs to the host role or to the device role. If that region does not match the current role, a mode-mismatch flag is raised.

Software reads both words through a small register port and writes them back. In the status word, event bits are cleared by writing 1 to them. The OTG summary bit and the role bit cannot be written. An event is recorded in the status word even when its enable bit is 0; the enable word only gates the interrupt line.

Top module: `usb_otg_irq_ctrl`

## Requirements
- R1: An enable bit of 0 blocks its source from the interrupt line. With every enable bit at 0, `irq` stays low whatever the status holds.
- R2: An event pulse sets its status bit on the next clock edge, even when the matching enable bit is 0. The bit positions are: frame start bit 3, disconnect bit 29, session request bit 30, wakeup bit 31.
- R3: A status write (`cfg_sel`=0) clears each event bit (1, 3, 29, 30, 31) whose write-data bit is 1. Bits written 0 keep their value.
- R4: The frame-start bit (bit 3) is only set by `sof_evt` while `spd_hs_fs` is 1. A pulse at low speed leaves the bit at 0.
- R5: Status bit 2 follows `otg_sub_any` one cycle later. Writing 1 to it has no effect, and it clears only when `otg_sub_any` falls.
- R6: Status bit 1 (mode mismatch) is set by a valid access to a host region while `is_host`=0, or to a device region while `is_host`=1. It is cleared by writing 1.
- R7: Status bit 0 reads `is_host` (0 = device role, 1 = host role) and cannot be written.
- R8: After reset, the status word reads 0 apart from bit 0, the enable word reads 0, and `irq` is low.
- R9: `irq` is a level that is high while any status bit and its enable bit are both 1. It stays high until that condition ends.
- R10: An event arriving in the same cycle as a write-one-to-clear of its bit leaves the bit set.
- R11: The enable word (`cfg_sel`=1) stores bits 1, 2, 3, 29, 30 and 31. All other bits ignore writes and read back as 0, so writing all ones reads back 0xE000000E.
- R12: The access stream is ignored while `acc_valid` is 0. An access whose region matches the current role sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_host | input | 1 | Current role, 1 = host |
| spd_hs_fs | input | 1 | Link running at high or full speed |
| sof_evt | input | 1 | Frame start sent (host) or received (device) |
| otg_sub_any | input | 1 | OR of the OTG sub-event status bits |
| wkup_evt | input | 1 | Resume / remote wakeup detected |
| sessreq_evt | input | 1 | Session request / new session detected |
| disc_evt | input | 1 | Disconnect detected |
| acc_valid | input | 1 | Decoded register access valid this cycle |
| acc_host_rgn | input | 1 | Access targets a host-only region |
| acc_dev_rgn | input | 1 | Access targets a device-only region |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = status word, 1 = enable word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Level interrupt to the processor |

## Verification
Each event source is pulsed once with its enable bit at 0 and once at 1. This separates recording the event from signalling it on `irq`. Clear writes are issued with 0 and with 1 in the bit's position, and one clear lands in the same cycle as a new frame-start pulse, which tests the set-over-clear priority. The access stream is tried with matching regions, mismatching regions, and with `acc_valid` low, so a wrong role comparison shows up apart from a missing valid qualifier. Frame-start pulses at low speed and the write-immune OTG summary bit cover the two bits whose setting or clearing depends on something other than the pulse and the write.

// File: rtl/usb_otg_irq_ctrl.sv
module usb_otg_irq_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_host,
  input  logic          spd_hs_fs,
  input  logic          sof_evt,
  input  logic          otg_sub_any,
  input  logic          wkup_evt,
  input  logic          sessreq_evt,
  input  logic          disc_evt,
  input  logic          acc_valid,
  input  logic          acc_host_rgn,
  input  logic          acc_dev_rgn,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq
);

  localparam int B_ROLE = 0;
  localparam int B_MISM = 1;
  localparam int B_OTG  = 2;
  localparam int B_SOF  = 3;
  localparam int B_DISC = 29;
  localparam int B_SESS = 30;
  localparam int B_WAKE = 31;

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] W1C_BITS = (ONE << B_MISM) | (ONE << B_SOF) |
                                       (ONE << B_DISC) | (ONE << B_SESS) | (ONE << B_WAKE);
  localparam logic [DW-1:0] EN_BITS  = W1C_BITS | (ONE << B_OTG);

  logic [DW-1:0] sticky_q, en_q, set_v, clr_v, status;
  logic          otg_q, mism;

  assign mism = acc_valid & ((acc_host_rgn & ~is_host) | (acc_dev_rgn & is_host));

  always_comb begin
    set_v = '0;
    set_v[B_MISM] = mism;
    set_v[B_SOF]  = sof_evt & spd_hs_fs;
    set_v[B_DISC] = disc_evt;
    set_v[B_SESS] = sessreq_evt;
    set_v[B_WAKE] = wkup_evt;
  end

  assign clr_v = (cfg_wr && !cfg_sel) ? (cfg_wdata & W1C_BITS) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      en_q     <= '0;
      otg_q    <= 1'b0;
    end else begin
      sticky_q <= ((sticky_q & ~clr_v) | set_v) & W1C_BITS;
      otg_q    <= otg_sub_any;
      if (cfg_wr && cfg_sel)
        en_q <= cfg_wdata & EN_BITS;
    end
  end

  always_comb begin
    status = sticky_q;
    status[B_OTG]  = otg_q;
    status[B_ROLE] = is_host;
  end

  assign cfg_rdata = cfg_sel ? en_q : status;
  assign irq = |(status & en_q);

  // R1
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R2
  sof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_evt && spd_hs_fs) |=> status[B_SOF]);

  // R2
  disc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disc_evt |=> status[B_DISC]);

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && cfg_wdata[B_WAKE] && !wkup_evt) |=> !status[B_WAKE]);

  // R4
  sof_lowspd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[B_SOF] && !(sof_evt && spd_hs_fs)) |=> !status[B_SOF]);

  // R5
  otg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    otg_sub_any |=> status[B_OTG]);

  // R5
  otg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !otg_sub_any |=> !status[B_OTG]);

  // R6
  mism_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_host_rgn && !is_host) |=> status[B_MISM]);

  // R9
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && cfg_wdata[B_SOF] && sof_evt && spd_hs_fs) |=> status[B_SOF]);

  // R11
  en_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_BITS) == '0);

endmodule

// File: tb/usb_otg_irq_ctrl_tb.sv
module usb_otg_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic is_host = 0, spd_hs_fs = 1, sof_evt = 0, otg_sub_any = 0;
  logic wkup_evt = 0, sessreq_evt = 0, disc_evt = 0;
  logic acc_valid = 0, acc_host_rgn = 0, acc_dev_rgn = 0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic irq;

  typedef struct {
    string       tag;
    logic        sel;
    logic [31:0] rd;
    logic        irq;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_otg_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .is_host(is_host), .spd_hs_fs(spd_hs_fs),
    .sof_evt(sof_evt), .otg_sub_any(otg_sub_any), .wkup_evt(wkup_evt),
    .sessreq_evt(sessreq_evt), .disc_evt(disc_evt), .acc_valid(acc_valid),
    .acc_host_rgn(acc_host_rgn), .acc_dev_rgn(acc_dev_rgn), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #2;
    sof_evt = 0; wkup_evt = 0; sessreq_evt = 0; disc_evt = 0;
    acc_valid = 0; acc_host_rgn = 0; acc_dev_rgn = 0;
    cfg_wr = 0; cfg_wdata = '0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    tick();
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
  endtask

  task automatic chk(input logic sel, input logic [31:0] rd, input logic ir, input string tag);
    exp_t e;
    tick();
    cfg_sel = sel;
    e.tag = tag; e.sel = sel; e.rd = rd; e.irq = ir;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (cfg_rdata !== e.rd || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, cfg_rdata, irq, e.rd, e.irq);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk(0, 32'h0, 0, "R8 status after reset");
    chk(1, 32'h0, 0, "R8 enable after reset");

    tick(); is_host = 1;
    chk(0, 32'h1, 0, "R7 role host");
    wr(0, 32'h1);
    chk(0, 32'h1, 0, "R7 role not writable");
    tick(); is_host = 0;
    chk(0, 32'h0, 0, "R7 role device");

    tick(); spd_hs_fs = 0; sof_evt = 1;
    chk(0, 32'h0, 0, "R4 sof at low speed");
    tick(); spd_hs_fs = 1; sof_evt = 1;
    chk(0, 32'h8, 0, "R2 sof latched while disabled R1");
    wr(1, 32'h8);
    chk(1, 32'h8, 1, "R9 enable sof raises irq");
    chk(1, 32'h8, 1, "R9 irq stays high");
    wr(0, 32'h0);
    chk(0, 32'h8, 1, "R3 write 0 keeps bit");
    wr(0, 32'h8);
    chk(0, 32'h0, 0, "R3 write 1 clears sof");
    tick(); sof_evt = 1;
    tick(); cfg_wr = 1; cfg_sel = 0; cfg_wdata = 32'h8; sof_evt = 1;
    chk(0, 32'h8, 1, "R10 set beats clear");
    wr(0, 32'h8);

    tick(); otg_sub_any = 1;
    chk(0, 32'h4, 0, "R5 otg summary follows");
    wr(0, 32'h4);
    chk(0, 32'h4, 0, "R5 otg write ignored");
    tick(); otg_sub_any = 0;
    chk(0, 32'h0, 0, "R5 otg clears with sub bits");

    tick(); acc_valid = 1; acc_dev_rgn = 1;
    chk(0, 32'h0, 0, "R12 matching region device");
    tick(); acc_valid = 0; acc_host_rgn = 1;
    chk(0, 32'h0, 0, "R12 invalid access ignored");
    tick(); acc_valid = 1; acc_host_rgn = 1;
    chk(0, 32'h2, 0, "R6 host region in device role");
    wr(0, 32'h2);
    chk(0, 32'h0, 0, "R6 mismatch cleared");
    tick(); is_host = 1; acc_valid = 1; acc_dev_rgn = 1;
    chk(0, 32'h3, 0, "R6 device region in host role");
    tick(); acc_valid = 1; acc_host_rgn = 1;
    wr(0, 32'h2);
    chk(0, 32'h1, 0, "R12 matching region host");
    tick(); is_host = 0;

    tick(); wkup_evt = 1; sessreq_evt = 1; disc_evt = 1;
    chk(0, 32'hE000_0000, 0, "R2 wakeup session disconnect latched");
    wr(1, 32'hFFFF_FFFF);
    chk(1, 32'hE000_000E, 1, "R11 reserved enable bits read 0");
    wr(1, 32'h2000_0000);
    chk(1, 32'h2000_0000, 1, "R1 disconnect enabled");
    wr(0, 32'h2000_0000);
    chk(0, 32'hC000_0000, 0, "R1 R3 disconnect cleared irq low");
    wr(0, 32'hC000_0000);
    chk(0, 32'h0, 0, "R3 wakeup session cleared");

    repeat (3) tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule